// File: doc/BRIEF.md
# SPI Status Flags and Interrupt Request Controller

This block holds the status and control register of a serial peripheral interface unit. It sits between the serial datapath and the CPU bus. The datapath reports two events: a received byte has moved into the receive holding register, and the transmit holding register has been loaded into the shifter. It also reports a slave-select consistency fault as a level. The CPU reaches the block through read and write strobes for the status register and the data register.

Four flags live here: receive-full, overflow, mode-fault and transmit-empty. They are set by datapath events and cleared as side effects of bus accesses. The writable control bits are the error-interrupt enable, the mode-fault detection enable and a baud-select field. The block combines the flags into one level-sensitive CPU interrupt request.

Each flag has its own small state machine:
- Receive: `RX_EMPTY` goes to `RX_FULL` when a byte lands, and `RX_FULL` goes to `RX_EMPTY` on a data-register read.
- Overflow: `OVF_CLEAR` goes to `OVF_SET` on a lost byte. `OVF_SET` goes to `OVF_ARMED` on a status read. `OVF_ARMED` goes to `OVF_CLEAR` on a data read.
- Mode fault: `MF_CLEAR` goes to `MF_SET` on a detected fault. `MF_SET` goes to `MF_ARMED` on a status read. `MF_ARMED` goes to `MF_CLEAR`, or back to `MF_SET` if the fault persists, on a status write.
- Transmit: `TX_EMPTY` goes to `TX_BUSY` on a data write, and `TX_BUSY` goes to `TX_EMPTY` on a shifter load.

Top module: `spi_stat_ctrl`

## Requirements
- R1: After reset the status read value is 8'h08 (only transmit-empty set), `baud_sel` is 0, and `irq` is 0.
- R2: The status read value is {receive-full[7], error-irq-enable[6], overflow[5], mode-fault[4], transmit-empty[3], mode-fault-detect-enable[2], baud[1:0]}, and `baud_sel` equals bits [1:0].
- R3: Receive-full sets on the clock after `rx_byte_done`. It clears on the clock after `data_rd`. When both are high in the same cycle, it ends set.
- R4: Overflow sets when `rx_byte_done` arrives while receive-full is already 1 and `data_rd` is low in that cycle.
- R5: Overflow clears only on a `data_rd` that follows a `stat_rd` made while overflow was 1. A `data_rd` without that earlier status read leaves it set.
- R6: Mode-fault sets when `ss_fault` is high while mode-fault-detect-enable (bit 2) is 1. `ss_fault` has no effect while that bit is 0.
- R7: Mode-fault clears on a `stat_wr` that follows a `stat_rd` made while mode-fault was 1. If a fault is detected in the cycle of that write, the flag ends set.
- R8: Transmit-empty clears on the clock after `data_wr` and sets on the clock after `tx_load`. When both are high in the same cycle, it ends clear.
- R9: A status write loads bits 6, 2, 1 and 0 from `stat_wdata`. The written values of bits 7, 5, 4 and 3 have no effect.
- R10: `irq` is (receive-full AND `rx_irq_en`) OR (transmit-empty AND `tx_irq_en`) OR (error-irq-enable AND (overflow OR mode-fault)). It follows the registered flags in the same cycle.
- R11: While error-irq-enable is 0, the overflow and mode-fault flags do not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte_done | input | 1 | Pulse: received byte moved into the receive holding register |
| tx_load | input | 1 | Pulse: transmit holding register loaded into the shifter |
| ss_fault | input | 1 | Level: slave-select line at an inconsistent level |
| rx_irq_en | input | 1 | Receiver interrupt enable from the neighbouring control register |
| tx_irq_en | input | 1 | Transmitter interrupt enable from the neighbouring control register |
| stat_rd | input | 1 | CPU read strobe for the status register |
| stat_wr | input | 1 | CPU write strobe for the status register |
| stat_wdata | input | 8 | CPU write data for the status register |
| data_rd | input | 1 | CPU read strobe for the data register |
| data_wr | input | 1 | CPU write strobe for the data register |
| stat_rdata | output | 8 | Status register read value |
| baud_sel | output | 2 | Baud-select field to the clock divider |
| modf_det_en | output | 1 | Mode-fault detection enable to the datapath |
| irq | output | 1 | CPU interrupt request level |

## Verification
A wrong state in any flag machine shows in `stat_rdata` and, when the matching enable is set, on `irq`, one clock after the strobe that caused it. An arming state that is entered by mistake, or that is never entered, is invisible until the clearing access arrives. At that point the flag clears when it should not, or stays set when it should clear. The bench therefore compares every field of the status value and `irq` against a reference model on every cycle of a long random mix of strobes. Directed sequences reach the arming, simultaneous-event and masking corners.

// File: rtl/spi_sc_pkg.sv
package spi_sc_pkg;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_e;

    typedef enum logic [1:0] {
        OVF_CLEAR = 2'd0,
        OVF_SET   = 2'd1,
        OVF_ARMED = 2'd2
    } ovf_state_e;

    typedef enum logic [1:0] {
        MF_CLEAR = 2'd0,
        MF_SET   = 2'd1,
        MF_ARMED = 2'd2
    } mf_state_e;

    typedef enum logic {
        TX_EMPTY = 1'b0,
        TX_BUSY  = 1'b1
    } tx_state_e;

endpackage

// File: rtl/spi_sc_rx.sv
module spi_sc_rx
    import spi_sc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_byte_done,
    input  logic stat_rd,
    input  logic data_rd,
    output logic rx_full,
    output logic ovf_flag
);

    rx_state_e  rx_q, rx_d;
    ovf_state_e ovf_q, ovf_d;
    logic       lost_byte;

    // A byte lands while the previous one is unread and not being read now.
    assign lost_byte = rx_byte_done && (rx_q == RX_FULL) && !data_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q  <= RX_EMPTY;
            ovf_q <= OVF_CLEAR;
        end else begin
            rx_q  <= rx_d;
            ovf_q <= ovf_d;
        end
    end

    always_comb begin
        rx_d = rx_q;
        unique case (rx_q)
            RX_EMPTY: if (rx_byte_done) rx_d = RX_FULL;
            RX_FULL:  if (data_rd && !rx_byte_done) rx_d = RX_EMPTY;
            default:  rx_d = RX_EMPTY;
        endcase
    end

    always_comb begin
        ovf_d = ovf_q;
        unique case (ovf_q)
            OVF_CLEAR: if (lost_byte) ovf_d = OVF_SET;
            OVF_SET:   if (stat_rd)   ovf_d = OVF_ARMED;
            OVF_ARMED: if (data_rd)   ovf_d = OVF_CLEAR;
            default:   ovf_d = OVF_CLEAR;
        endcase
    end

    always_comb begin
        rx_full  = (rx_q == RX_FULL);
        ovf_flag = (ovf_q != OVF_CLEAR);
    end

    // R3
    rxf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_byte_done) |=> !rx_full);

    // R3
    rxf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_done |=> rx_full);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte_done && rx_full && !data_rd) |=> ovf_flag);

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q == OVF_SET) |=> ovf_flag);

endmodule

// File: rtl/spi_sc_modf.sv
module spi_sc_modf
    import spi_sc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ss_fault,
    input  logic det_en,
    input  logic stat_rd,
    input  logic stat_wr,
    output logic modf_flag
);

    mf_state_e mf_q, mf_d;
    logic      fault_seen;

    assign fault_seen = ss_fault && det_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mf_q <= MF_CLEAR;
        else        mf_q <= mf_d;
    end

    always_comb begin
        mf_d = mf_q;
        unique case (mf_q)
            MF_CLEAR: if (fault_seen) mf_d = MF_SET;
            MF_SET:   if (stat_rd)    mf_d = MF_ARMED;
            MF_ARMED: if (stat_wr)    mf_d = fault_seen ? MF_SET : MF_CLEAR;
            default:  mf_d = MF_CLEAR;
        endcase
    end

    always_comb modf_flag = (mf_q != MF_CLEAR);

    // R6
    modf_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_en && !modf_flag) |=> !modf_flag);

    // R7
    modf_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_seen |=> modf_flag);

endmodule

// File: rtl/spi_sc_tx.sv
module spi_sc_tx
    import spi_sc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic data_wr,
    input  logic tx_load,
    output logic tx_empty
);

    tx_state_e tx_q, tx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= TX_EMPTY;
        else        tx_q <= tx_d;
    end

    always_comb begin
        tx_d = tx_q;
        unique case (tx_q)
            TX_EMPTY: if (data_wr) tx_d = TX_BUSY;
            TX_BUSY:  if (tx_load && !data_wr) tx_d = TX_EMPTY;
            default:  tx_d = TX_EMPTY;
        endcase
    end

    always_comb tx_empty = (tx_q == TX_EMPTY);

    // R8
    txe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !tx_empty);

    // R8
    txe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !data_wr) |=> tx_empty);

endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl #(
    parameter int BAUD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_byte_done,
    input  logic              tx_load,
    input  logic              ss_fault,
    input  logic              rx_irq_en,
    input  logic              tx_irq_en,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic [BAUD_W+5:0] stat_wdata,
    input  logic              data_rd,
    input  logic              data_wr,
    output logic [BAUD_W+5:0] stat_rdata,
    output logic [BAUD_W-1:0] baud_sel,
    output logic              modf_det_en,
    output logic              irq
);

    localparam int REG_W      = BAUD_W + 6;
    localparam int POS_MFEN   = BAUD_W;
    localparam int POS_TXE    = BAUD_W + 1;
    localparam int POS_MODF   = BAUD_W + 2;
    localparam int POS_OVF    = BAUD_W + 3;
    localparam int POS_ERRIE  = BAUD_W + 4;
    localparam int POS_RXF    = BAUD_W + 5;

    logic              rx_full, ovf_flag, modf_flag, tx_empty;
    logic              errie_q;
    logic              mfen_q;
    logic [BAUD_W-1:0] baud_q;

    // Writable control bits: error enable, detection enable, baud field.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            errie_q <= 1'b0;
            mfen_q  <= 1'b0;
            baud_q  <= '0;
        end else if (stat_wr) begin
            errie_q <= stat_wdata[POS_ERRIE];
            mfen_q  <= stat_wdata[POS_MFEN];
            baud_q  <= stat_wdata[BAUD_W-1:0];
        end
    end

    spi_sc_rx u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_byte_done (rx_byte_done),
        .stat_rd      (stat_rd),
        .data_rd      (data_rd),
        .rx_full      (rx_full),
        .ovf_flag     (ovf_flag)
    );

    spi_sc_modf u_modf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_fault  (ss_fault),
        .det_en    (mfen_q),
        .stat_rd   (stat_rd),
        .stat_wr   (stat_wr),
        .modf_flag (modf_flag)
    );

    spi_sc_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_wr  (data_wr),
        .tx_load  (tx_load),
        .tx_empty (tx_empty)
    );

    always_comb begin
        stat_rdata                 = '0;
        stat_rdata[POS_RXF]        = rx_full;
        stat_rdata[POS_ERRIE]      = errie_q;
        stat_rdata[POS_OVF]        = ovf_flag;
        stat_rdata[POS_MODF]       = modf_flag;
        stat_rdata[POS_TXE]        = tx_empty;
        stat_rdata[POS_MFEN]       = mfen_q;
        stat_rdata[BAUD_W-1:0]     = baud_q;
        baud_sel                   = baud_q;
        modf_det_en                = mfen_q;
        irq = (rx_full && rx_irq_en) || (tx_empty && tx_irq_en)
           || (errie_q && (ovf_flag || modf_flag));
    end

    // R11
    err_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rdata[POS_ERRIE] && !rx_irq_en && !tx_irq_en) |-> !irq);

    // R9
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (baud_sel == $past(stat_wdata[BAUD_W-1:0])));

    initial begin
        // R2
        width_chk: assert (REG_W == $bits(stat_rdata));
    end

endmodule

// File: tb/spi_stat_ctrl_bench.sv
module spi_stat_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_byte_done = 0, tx_load = 0, ss_fault = 0;
    logic       rx_irq_en = 0, tx_irq_en = 0;
    logic       stat_rd = 0, stat_wr = 0, data_rd = 0, data_wr = 0;
    logic [7:0] stat_wdata = 0;
    logic [7:0] stat_rdata;
    logic [1:0] baud_sel;
    logic       modf_det_en, irq;

    int checks = 0;
    int failures = 0;

    // reference model state
    bit       m_rxf, m_txe, m_errie, m_mfen;
    int       m_ovf, m_mf;
    bit [1:0] m_baud;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_stat_ctrl u_spi_stat_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_byte_done(rx_byte_done), .tx_load(tx_load),
        .ss_fault(ss_fault), .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .data_rd(data_rd), .data_wr(data_wr), .stat_rdata(stat_rdata),
        .baud_sel(baud_sel), .modf_det_en(modf_det_en), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] exp_reg();
        return {m_rxf, m_errie, m_ovf != 0, m_mf != 0, m_txe, m_mfen, m_baud};
    endfunction

    function automatic bit exp_irq();
        return (m_rxf && rx_irq_en) || (m_txe && tx_irq_en)
            || (m_errie && (m_ovf != 0 || m_mf != 0));
    endfunction

    task automatic model_reset();
        m_rxf = 0; m_txe = 1; m_errie = 0; m_mfen = 0;
        m_ovf = 0; m_mf = 0; m_baud = 0;
    endtask

    // advance model using the inputs applied in this cycle
    task automatic model_step();
        bit lost, fseen;
        lost  = rx_byte_done && m_rxf && !data_rd;
        fseen = ss_fault && m_mfen;
        case (m_ovf)
            0: if (lost) m_ovf = 1;
            1: if (stat_rd) m_ovf = 2;
            default: if (data_rd) m_ovf = 0;
        endcase
        case (m_mf)
            0: if (fseen) m_mf = 1;
            1: if (stat_rd) m_mf = 2;
            default: if (stat_wr) m_mf = fseen ? 1 : 0;
        endcase
        if (rx_byte_done) m_rxf = 1; else if (data_rd) m_rxf = 0;
        if (data_wr) m_txe = 0; else if (tx_load) m_txe = 1;
        if (stat_wr) begin
            m_errie = stat_wdata[6]; m_mfen = stat_wdata[2]; m_baud = stat_wdata[1:0];
        end
    endtask

    task automatic compare_all();
        bit [7:0] e;
        e = exp_reg();
        chk("R3 receive-full", stat_rdata[7], e[7]);
        chk("R4/R5 overflow", stat_rdata[5], e[5]);
        chk("R6/R7 mode-fault", stat_rdata[4], e[4]);
        chk("R8 transmit-empty", stat_rdata[3], e[3]);
        chk("R9 control bits", {stat_rdata[6], stat_rdata[2:0]}, {e[6], e[2:0]});
        chk("R2 baud_sel", baud_sel, e[1:0]);
        chk("R10 irq", irq, exp_irq());
    endtask

    task automatic idle_inputs();
        rx_byte_done = 0; tx_load = 0; ss_fault = 0;
        stat_rd = 0; stat_wr = 0; data_rd = 0; data_wr = 0; stat_wdata = 0;
    endtask

    // inputs already set; clock one edge, update model, compare
    task automatic cycle();
        @(posedge clk);
        model_step();
        #1;
        compare_all();
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset value", stat_rdata, 8'h08);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset baud", baud_sel, 0);
        rst_n = 1;
        @(negedge clk);

        // R9: writes to flag bits have no effect, control bits load
        stat_wr = 1; stat_wdata = 8'hFF; cycle();
        chk("R9 write 0xFF", stat_rdata, 8'h4F);
        stat_wr = 1; stat_wdata = 8'h00; cycle();
        chk("R9 write 0x00", stat_rdata, 8'h08);

        // R3 / R4 / R5 directed overflow sequence
        rx_byte_done = 1; cycle();
        rx_byte_done = 1; cycle();
        chk("R4 overflow set", stat_rdata[5], 1);
        data_rd = 1; cycle();
        chk("R5 overflow kept without status read", stat_rdata[5], 1);
        chk("R3 receive-full cleared by data read", stat_rdata[7], 0);
        stat_rd = 1; cycle();
        data_rd = 1; cycle();
        chk("R5 overflow cleared after status+data read", stat_rdata[5], 0);
        // R3 simultaneous land and read keeps full, no overflow
        rx_byte_done = 1; cycle();
        rx_byte_done = 1; data_rd = 1; cycle();
        chk("R3 simultaneous keeps full", stat_rdata[7], 1);
        chk("R4 no overflow when read same cycle", stat_rdata[5], 0);
        data_rd = 1; cycle();

        // R6: fault ignored when detection disabled
        ss_fault = 1; cycle();
        chk("R6 fault ignored when disabled", stat_rdata[4], 0);
        stat_wr = 1; stat_wdata = 8'h44; cycle();
        ss_fault = 1; cycle();
        chk("R6 fault detected", stat_rdata[4], 1);
        chk("R10 error irq", irq, 1);
        // R7: persisting fault on clearing write keeps flag
        stat_rd = 1; cycle();
        stat_wr = 1; stat_wdata = 8'h04; ss_fault = 1; cycle();
        chk("R7 persisting fault keeps flag", stat_rdata[4], 1);
        chk("R11 errie=0 masks irq", irq, 0);
        stat_rd = 1; cycle();
        stat_wr = 1; stat_wdata = 8'h04; cycle();
        chk("R7 mode-fault cleared", stat_rdata[4], 0);

        // R8 simultaneous write and load leaves transmit busy
        data_wr = 1; cycle();
        data_wr = 1; tx_load = 1; cycle();
        chk("R8 write wins over load", stat_rdata[3], 0);
        tx_load = 1; cycle();
        chk("R8 load sets transmit-empty", stat_rdata[3], 1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            rx_byte_done = ($urandom % 4) == 0;
            tx_load      = ($urandom % 4) == 0;
            ss_fault     = ($urandom % 6) == 0;
            stat_rd      = ($urandom % 3) == 0;
            stat_wr      = ($urandom % 8) == 0;
            data_rd      = ($urandom % 4) == 0;
            data_wr      = ($urandom % 4) == 0;
            stat_wdata   = 8'($urandom);
            if (i % 97 == 0) begin
                rx_irq_en = $urandom % 2;
                tx_irq_en = $urandom % 2;
            end
            cycle();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule